// File: doc/BRIEF.md
# Multi-Address I2C Slave Byte Engine

This block is the byte-level target side of an I2C bus. It watches the synchronized SCL and SDA pins and finds START, repeated START and STOP conditions. It then compares the received 7-bit address against a set of programmable address slots and against the general call address. When the address matches, it acknowledges and moves whole bytes between the bus and a single data register. Each pin is modelled as a sampled input plus an open-drain pull-low enable.

A host processor reaches the engine through a small strobe-based register bus. The engine raises an interrupt after every byte that ends with an acknowledge. It then keeps SCL low until the host either reads or writes the data register. A two-bit cause field tells the host why the interrupt fired. The engine locks itself if the host touches the data register twice for one interrupt. Only a soft-reset write to the control register frees it.

Register map (byte offsets on `bus_addr`):
- 0: data register. A read returns the last byte captured; a write loads the next byte to send.
- 1: control register. Bit 0 enables the STOP interrupt. Writing 1 to bit 7 performs a soft reset; this bit reads back as 0.
- 2: status register. Bit 0 is the pending flag. Bit 1 is the direction. Bits 3:2 hold the cause. Bit 4 is the general-call flag. Bit 5 is the lock flag. Writing 1 to bit 4 clears the general-call flag.
- 4 + n: address slot n, 7 bits wide.

Top module: `i2c_multi_slave`

## Requirements
- R1: After reset no pin is pulled low and the pending flag is 0. Status and control read 0x00. Address slot 0 reads 0x55 and slots 1 to 3 read 0x00.
- R2: When a START is followed by a matching address, the slave pulls SDA low in the ninth clock. It then sets the pending flag with cause 00 (START), and the data register reads back the address byte with the R/W bit as its LSB.
- R3: An address equal to any one of the four slots is accepted, and a programmed slot reads back its value. An address that matches no slot and is not zero is not acknowledged, raises no interrupt and leaves the engine idle.
- R4: Address 0x00 (general call) is acknowledged and sets status bit 4. That bit stays set across later bytes, STOPs and soft resets until the host writes 1 to status bit 4.
- R5: A repeated START that arrives without an intervening STOP and carries a matching address gives cause 01. It may change the direction.
- R6: Status bit 1 takes the R/W bit of the address. When it is 0, each received byte is acknowledged, the cause is 10 and the byte is placed in the data register. When it is 1, the data register is shifted out MSB first.
- R7: While the slave is sending, a master ACK after a byte gives an interrupt with cause 10 and SCL is held low. A master NACK gives no interrupt and the engine returns to idle with both pins released.
- R8: After every acknowledged byte, SCL stays low until a read or a write of the data register clears the pending flag. The clock is released within a few cycles after that access.
- R9: A STOP returns the engine to idle. It raises an interrupt with cause 11 only when control bit 0 is 1 and a matching address has been received since the last STOP.
- R10: A second data-register access for the same interrupt sets status bit 5. While bit 5 is set the engine ignores the bus: no ACK, no stretch and no interrupt. Writing 1 to control bit 7 clears bit 5 and returns the engine to normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | Pull SCL low (clock stretch) |
| sda_oe_o | output | 1 | Pull SDA low (ACK or data 0) |
| bus_wr | input | 1 | Host write strobe, one cycle |
| bus_rd | input | 1 | Host read strobe, one cycle |
| bus_addr | input | BUS_AW | Host register offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational) |
| irq_o | output | 1 | Pending-interrupt flag |

## Verification
The bench uses the default parameters: four address slots and a two-stage pin synchronizer. With four slots, the bench can program the highest slot and check that it matches. Because slots 1 to 3 reset to zero, the general-call path also overlaps with zero-valued slots. The two-stage synchronizer fixes the delay from an SCL edge to the stretch at a few cycles. That lets an SCL half-period of ten clocks expose both a missing stretch and a stretch that is released too late. One transaction sequence covers both directions, a master NACK, a repeated START, STOP with and without the enable, a non-matching address, and the lock followed by its recovery.

// File: rtl/i2cs_pkg.sv
`timescale 1ns/1ps
package i2cs_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADR_W     = 7;
  localparam int REG_DATA  = 0;
  localparam int REG_CTRL  = 1;
  localparam int REG_STAT  = 2;
  localparam int REG_SLOT0 = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_RX, S_TX, S_ACK, S_MACK, S_HOLD, S_LOCK
  } eng_state_t;

  typedef enum logic [1:0] {
    C_START  = 2'b00,
    C_RSTART = 2'b01,
    C_DATA   = 2'b10,
    C_STOP   = 2'b11
  } irq_cause_t;
endpackage

// File: rtl/i2cs_rst_sync.sv
`timescale 1ns/1ps
module i2cs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = pipe_q[STAGES-1];
endmodule

// File: rtl/i2cs_pin_sync.sv
`timescale 1ns/1ps
module i2cs_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_pin,
  input  logic sda_pin,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_seen,
  output logic stop_seen
);
  // index STAGES holds the previous synchronized sample
  logic [STAGES:0] scl_pipe, sda_pipe;
  logic scl_now, scl_old, sda_now, sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_pin};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_pin};
    end
  end

  assign scl_now    = scl_pipe[STAGES-1];
  assign scl_old    = scl_pipe[STAGES];
  assign sda_now    = sda_pipe[STAGES-1];
  assign sda_old    = sda_pipe[STAGES];
  assign sda_lvl    = sda_now;
  assign scl_rise   = scl_now & ~scl_old;
  assign scl_fall   = ~scl_now & scl_old;
  assign start_seen = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_seen  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2cs_addr_match.sv
`timescale 1ns/1ps
module i2cs_addr_match #(
  parameter int NUM_SLOTS = 4,
  parameter int AW        = 7
) (
  input  logic [NUM_SLOTS-1:0][AW-1:0] slots,
  input  logic [AW-1:0]                cand,
  output logic                         hit,
  output logic                         gcall
);
  logic [NUM_SLOTS-1:0] eq;

  genvar g;
  generate
    for (g = 0; g < NUM_SLOTS; g++) begin : g_cmp
      assign eq[g] = (slots[g] == cand);
    end
  endgenerate

  assign gcall = (cand == '0);
  assign hit   = (|eq) | gcall;
endmodule

// File: rtl/i2c_multi_slave.sv
`timescale 1ns/1ps
module i2c_multi_slave
  import i2cs_pkg::*;
#(
  parameter int              NUM_SLOTS   = 4,
  parameter int              SYNC_STAGES = 2,
  parameter int              BUS_AW      = 3,
  parameter logic [ADR_W-1:0] SLOT0_RST  = 7'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_W - 1);

  logic rst_sn;
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic hit, gcall;

  eng_state_t st_q, st_d;
  irq_cause_t cause_q, cause_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d, dreg_q, dreg_d;
  logic dir_q, dir_d, addressed_q, addressed_d, rep_q, rep_d;
  logic irq_q, irq_d, gc_q, gc_d, served_q, served_d;
  logic stop_en_q, stop_en_d, nack_q, nack_d;
  logic [NUM_SLOTS-1:0][ADR_W-1:0] slot_q, slot_d;

  logic data_acc, soft_rst, gc_clr;

  i2cs_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  i2cs_pin_sync #(.STAGES(SYNC_STAGES)) u_pins (
    .clk(clk), .rst_n(rst_sn), .scl_pin(scl_i), .sda_pin(sda_i),
    .sda_lvl(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_seen(start_det), .stop_seen(stop_det)
  );

  i2cs_addr_match #(.NUM_SLOTS(NUM_SLOTS), .AW(ADR_W)) u_match (
    .slots(slot_q), .cand(sh_q[BYTE_W-1:1]), .hit(hit), .gcall(gcall)
  );

  assign data_acc = (bus_wr | bus_rd) && (bus_addr == BUS_AW'(REG_DATA));
  assign soft_rst = bus_wr && (bus_addr == BUS_AW'(REG_CTRL)) && bus_wdata[7];
  assign gc_clr   = bus_wr && (bus_addr == BUS_AW'(REG_STAT)) && bus_wdata[4];

  // next-state process
  always_comb begin
    st_d = st_q;         cause_d = cause_q;     cnt_d = cnt_q;
    sh_d = sh_q;         dreg_d = dreg_q;       dir_d = dir_q;
    addressed_d = addressed_q;                  rep_d = rep_q;
    irq_d = irq_q;       gc_d = gc_q;           served_d = served_q;
    stop_en_d = stop_en_q;                      nack_d = nack_q;
    slot_d = slot_q;

    // host side
    if (bus_wr && bus_addr == BUS_AW'(REG_CTRL)) stop_en_d = bus_wdata[0];
    if (gc_clr) gc_d = 1'b0;
    if (bus_wr && bus_addr == BUS_AW'(REG_DATA)) dreg_d = bus_wdata;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (bus_wr && bus_addr == BUS_AW'(REG_SLOT0 + i)) slot_d[i] = bus_wdata[ADR_W-1:0];
    end
    if (data_acc && irq_q) begin
      irq_d    = 1'b0;
      served_d = 1'b1;
    end

    // bus side
    if (soft_rst) begin
      st_d = S_IDLE; irq_d = 1'b0; served_d = 1'b0;
      addressed_d = 1'b0; cnt_d = '0;
    end else if (st_q != S_LOCK) begin
      if (stop_det) begin
        st_d = S_IDLE;
        if (addressed_q && stop_en_q) begin
          irq_d = 1'b1; cause_d = C_STOP; served_d = 1'b0;
        end
        addressed_d = 1'b0;
      end else if (start_det) begin
        st_d = S_ADDR; cnt_d = '0; rep_d = addressed_q;
      end else begin
        unique case (st_q)
          S_ADDR, S_RX: begin
            if (scl_rise) begin
              sh_d  = {sh_q[BYTE_W-2:0], sda_s};
              cnt_d = cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == LAST_BIT) begin
              cnt_d = '0;
              if (st_q == S_RX) begin
                st_d = S_ACK; dreg_d = sh_q; cause_d = C_DATA;
              end else if (hit) begin
                st_d = S_ACK; dreg_d = sh_q; dir_d = sh_q[0];
                addressed_d = 1'b1;
                cause_d = rep_q ? C_RSTART : C_START;
                if (gcall) gc_d = 1'b1;
              end else begin
                st_d = S_IDLE; addressed_d = 1'b0;
              end
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              st_d = S_HOLD; irq_d = 1'b1; served_d = 1'b0;
            end
          end
          S_HOLD: begin
            if (!irq_q) begin
              cnt_d = '0;
              if (dir_q) begin
                st_d = S_TX; sh_d = dreg_q;
              end else begin
                st_d = S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
              if (cnt_q == LAST_TX) begin
                st_d = S_MACK; cnt_d = '0;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              nack_d = sda_s;
            end else if (scl_fall) begin
              if (!nack_q) begin
                st_d = S_HOLD; irq_d = 1'b1; cause_d = C_DATA; served_d = 1'b0;
              end else begin
                st_d = S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
      if (data_acc && !irq_q && served_q) st_d = S_LOCK;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q <= S_IDLE;        cause_q <= C_START;   cnt_q <= '0;
      sh_q <= '0;            dreg_q <= '0;         dir_q <= 1'b0;
      addressed_q <= 1'b0;   rep_q <= 1'b0;        irq_q <= 1'b0;
      gc_q <= 1'b0;          served_q <= 1'b0;     stop_en_q <= 1'b0;
      nack_q <= 1'b1;
      for (int i = 0; i < NUM_SLOTS; i++) slot_q[i] <= (i == 0) ? SLOT0_RST : '0;
    end else begin
      st_q <= st_d;          cause_q <= cause_d;   cnt_q <= cnt_d;
      sh_q <= sh_d;          dreg_q <= dreg_d;     dir_q <= dir_d;
      addressed_q <= addressed_d;                  rep_q <= rep_d;
      irq_q <= irq_d;        gc_q <= gc_d;         served_q <= served_d;
      stop_en_q <= stop_en_d;                      nack_q <= nack_d;
      slot_q <= slot_d;
    end
  end

  assign scl_oe_o = (st_q == S_HOLD);
  assign sda_oe_o = (st_q == S_ACK) || (st_q == S_TX && !sh_q[BYTE_W-1]);
  assign irq_o    = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == BUS_AW'(REG_DATA)) bus_rdata = dreg_q;
    if (bus_addr == BUS_AW'(REG_CTRL)) bus_rdata = {7'b0, stop_en_q};
    if (bus_addr == BUS_AW'(REG_STAT))
      bus_rdata = {2'b00, (st_q == S_LOCK), gc_q, cause_q, dir_q, irq_q};
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (bus_addr == BUS_AW'(REG_SLOT0 + i)) bus_rdata = {1'b0, slot_q[i]};
    end
  end

  // assertions
  a_r8_stretch_on_irq: assert property (@(posedge clk) disable iff (!rst_sn)
    ($rose(irq_q) && cause_q != C_STOP) |-> scl_oe_o);

  a_r7_nack_to_idle: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == S_MACK && nack_q && scl_fall && !start_det && !stop_det && !soft_rst && !data_acc)
    |=> (st_q == S_IDLE && !irq_q));

  a_r9_stop_needs_address: assert property (@(posedge clk) disable iff (!rst_sn)
    (stop_det && !addressed_q && !irq_q && !soft_rst) |=> !irq_q);

  a_r4_gc_sticky: assert property (@(posedge clk) disable iff (!rst_sn)
    (gc_q && !gc_clr) |=> gc_q);

  a_r10_double_access: assert property (@(posedge clk) disable iff (!rst_sn)
    (data_acc && !irq_q && served_q && !soft_rst && st_q != S_LOCK) |=> (st_q == S_LOCK));

  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == S_LOCK && !soft_rst) |=> (st_q == S_LOCK && !scl_oe_o && !sda_oe_o));
endmodule

// File: tb/tb_i2c_multi_slave.sv
`timescale 1ns/1ps
module tb_i2c_multi_slave;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl, m_sda;
  logic bus_wr, bus_rd;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic scl_oe, sda_oe, irq;
  wire  scl_line = m_scl & ~scl_oe;
  wire  sda_line = m_sda & ~sda_oe;

  int n_cmp = 0, n_bad = 0, mon_cmp = 0, mon_bad = 0;
  int hold_mode = 2;     // 0 expect released, 1 expect held, 2 unknown
  logic done = 1'b0;

  always #2 clk = ~clk;

  i2c_multi_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq)
  );

  // per-clock comparison of the clock-stretch output against the model
  always @(negedge clk) begin
    if (rst_n && hold_mode != 2) begin
      mon_cmp++;
      if (scl_oe !== (hold_mode == 1)) begin
        mon_bad++;
        $display("FAIL R8 scl hold got %0b expected %0b at %0t", scl_oe, (hold_mode == 1), $time);
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic host_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic scl_up();
    m_scl = 1'b1;
    while (scl_line !== 1'b1) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    wt(3); m_sda = b; wt(H - 3); scl_up(); wt(H); m_scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wt(3); m_sda = 1'b1; wt(H - 3); scl_up(); wt(H / 2); b = sda_line; wt(H / 2); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(ack);
    wt(H);
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic give_nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_in(b);
      v[i] = b;
    end
    bit_out(give_nack);
    wt(H);
  endtask

  task automatic start_cond();
    wt(3); m_sda = 1'b1; wt(H - 3); scl_up(); wt(H); m_sda = 1'b0; wt(H); m_scl = 1'b0;
  endtask

  task automatic stop_cond();
    wt(3); m_sda = 1'b0; wt(H - 3); scl_up(); wt(H); m_sda = 1'b1; wt(H);
  endtask

  task automatic expect_irq(input string tag, input logic [7:0] stat, input logic held);
    logic [7:0] r;
    wt(20);
    if (held) hold_mode = 1;
    wt(8);
    chk({tag, " irq pin"}, irq, 1);
    host_read(3'd2, r);
    chk({tag, " status"}, r, stat);
  endtask

  task automatic release_hold();
    hold_mode = 2; wt(8); hold_mode = 0;
  endtask

  initial begin
    logic [7:0] r;
    logic ack;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    wt(5); rst_n = 1'b1; wt(5);
    hold_mode = 0;

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 sda_oe", sda_oe, 0);
    host_read(3'd2, r); chk("R1 status", r, 8'h00);
    host_read(3'd1, r); chk("R1 control", r, 8'h00);
    host_read(3'd4, r); chk("R1 slot0", r, 8'h55);
    host_read(3'd5, r); chk("R1 slot1", r, 8'h00);
    host_read(3'd6, r); chk("R1 slot2", r, 8'h00);
    host_read(3'd7, r); chk("R1 slot3", r, 8'h00);

    // R2 address write to slot0
    start_cond();
    hold_mode = 2;
    send_byte(8'hAA, ack); chk("R2 address ack", ack, 0);
    expect_irq("R2", 8'h01, 1'b1);
    host_read(3'd0, r); chk("R2 data holds address", r, 8'hAA);
    release_hold();
    chk("R8 irq cleared by read", irq, 0);

    // R6 receive a byte
    hold_mode = 2;
    send_byte(8'h3C, ack); chk("R6 rx ack", ack, 0);
    expect_irq("R6 rx", 8'h09, 1'b1);
    host_read(3'd0, r); chk("R6 rx data", r, 8'h3C);
    release_hold();

    // R5 repeated start, read direction, R6 transmit, R7 ack and nack
    start_cond();
    hold_mode = 2;
    send_byte(8'hAB, ack); chk("R5 rstart ack", ack, 0);
    expect_irq("R5 rstart", 8'h07, 1'b1);
    host_write(3'd0, 8'hA5);
    hold_mode = 2;
    recv_byte(r, 1'b0); chk("R6 tx byte", r, 8'hA5);
    expect_irq("R7 master ack", 8'h0B, 1'b1);
    host_write(3'd0, 8'h96);
    hold_mode = 2;
    recv_byte(r, 1'b1); chk("R6 tx second byte", r, 8'h96);
    wt(20); hold_mode = 0; wt(10);
    chk("R7 nack no irq", irq, 0);
    host_read(3'd2, r); chk("R7 nack status", r, 8'h0A);

    // R9 stop without enable
    stop_cond(); wt(20);
    chk("R9 stop no enable", irq, 0);

    // R3 slot3, R9 stop interrupt
    host_write(3'd1, 8'h01);
    host_write(3'd7, 8'h6A);
    host_read(3'd7, r); chk("R3 slot3 readback", r, 8'h6A);
    start_cond();
    hold_mode = 2;
    send_byte(8'hD4, ack); chk("R3 slot3 ack", ack, 0);
    expect_irq("R3 slot3", 8'h01, 1'b1);
    host_read(3'd0, r); chk("R3 slot3 data", r, 8'hD4);
    release_hold();
    stop_cond(); wt(20);
    chk("R9 stop irq", irq, 1);
    host_read(3'd2, r); chk("R9 stop cause", r, 8'h0D);
    host_read(3'd0, r); wt(4);
    chk("R9 stop irq cleared", irq, 0);

    // R3 non-matching address
    start_cond();
    send_byte(8'h24, ack); chk("R3 nonmatch nack", ack, 1);
    wt(20); chk("R3 nonmatch no irq", irq, 0);
    stop_cond(); wt(20);
    chk("R9 unaddressed stop", irq, 0);

    // R4 general call
    start_cond();
    hold_mode = 2;
    send_byte(8'h00, ack); chk("R4 gc ack", ack, 0);
    expect_irq("R4 gc", 8'h11, 1'b1);
    host_read(3'd0, r); chk("R4 gc data", r, 8'h00);
    release_hold();
    stop_cond(); wt(20);
    host_read(3'd2, r); chk("R4 gc after stop", r, 8'h1D);
    host_read(3'd0, r);
    host_read(3'd2, r); chk("R4 gc sticky", r, 8'h1C);
    host_write(3'd2, 8'h10);
    host_read(3'd2, r); chk("R4 gc cleared", r, 8'h0C);

    // R10 double access lock
    start_cond();
    hold_mode = 2;
    send_byte(8'hAA, ack); chk("R10 address ack", ack, 0);
    expect_irq("R10", 8'h01, 1'b1);
    hold_mode = 2;
    host_read(3'd0, r);
    host_read(3'd0, r);
    wt(8); hold_mode = 0;
    host_read(3'd2, r); chk("R10 locked status", r, 8'h20);
    send_byte(8'h11, ack); chk("R10 locked no ack", ack, 1);
    stop_cond(); wt(20);
    chk("R10 locked no stop irq", irq, 0);
    host_write(3'd1, 8'h81);
    host_read(3'd2, r); chk("R10 soft reset status", r, 8'h00);
    start_cond();
    hold_mode = 2;
    send_byte(8'hAA, ack); chk("R10 recovered ack", ack, 0);
    expect_irq("R10 recovered", 8'h01, 1'b1);
    host_read(3'd0, r);
    release_hold();
    stop_cond(); wt(20);
    chk("R9 stop irq after recovery", irq, 1);
    host_read(3'd0, r); wt(4);
    chk("R9 cleared", irq, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + mon_cmp, n_bad + mon_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + mon_cmp + 1, n_bad + mon_bad + 1);
      $finish;
    end
  end
endmodule